// File: doc/BRIEF.md
# Tree Pseudo-LRU Replacement Unit

This unit keeps the replacement state of a set-associative cache. Each set holds a binary tree of direction bits, one fewer bit than the number of ways. An exact recency order would need far more storage per set: 45 bits at 16 ways. The cache controller presents a lookup set index and reads back the way to evict. The controller also reports hits and fills, and each of these moves the tree of the affected set away from the way just used.

The hit port and the fill port each carry a strobe, a set index and a way. A global update enable gates both ports. The victim is a purely combinational function of the stored bits of the looked-up set. The number of ways is a power of two, at least two. Tag compare, data arrays and miss handling live elsewhere.

Top module: `plru_tree_repl`

## Requirements
- R1: An active-low asynchronous reset clears every tree bit to 0, so every set reports way 0 as its victim while in reset and after it.
- R2: The victim is found by walking from the root node: a bit of 0 selects the lower-numbered subtree and a bit of 1 selects the higher-numbered subtree. It is produced combinationally from the stored bits of the set on `lkp_set_i`, with no clock edge in between. For 4 ways, the root selects between {0,1} and {2,3}, and one further bit selects within each pair.
- R3: A hit (`hit_vld_i` and `upd_en_i` high at a rising edge) sets every node on the path of `hit_way_i` in set `hit_set_i` to point away from that way.
- R4: A fill (`fill_vld_i` and `upd_en_i` high at a rising edge) sets every node on the path of `fill_way_i` in set `fill_set_i` to point away from that way.
- R5: While `upd_en_i` is low, no set changes, whatever the strobes carry. Updates take effect at the rising edge on which they are presented, and no set other than the one addressed is changed.
- R6: When a hit and a fill address the same set in one cycle, only the fill is applied, starting from the set's bits before that edge.
- R7: A hit and a fill to different sets in the same cycle are both applied.
- R8: Right after a hit or fill to a set, that set's victim is never the way just touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_set_i | input | SET_W | Set whose victim is reported |
| victim_o | output | WAY_W | Victim way of the looked-up set |
| upd_en_i | input | 1 | Global enable for both update ports |
| hit_vld_i | input | 1 | Hit update strobe |
| hit_set_i | input | SET_W | Set of the hit |
| hit_way_i | input | WAY_W | Way that hit |
| fill_vld_i | input | 1 | Fill update strobe |
| fill_set_i | input | SET_W | Set being filled |
| fill_way_i | input | WAY_W | Way being filled |

## Verification
Some properties are checked on every cycle:
- A touched way is never the next victim of its set, for both hits and fills.
- The victim stays frozen while updates are disabled.
- On a same-set collision, the stored bits take the fill result.
- On a different-set dual update, both stored rows are written.

Only the bench scenarios can show the following:
- The exact victim sequence produced by the tree walk.
- That reset clears every set.
- That the lookup is combinational.
- That untouched sets stay unchanged.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // Heap-ordered tree: node n has children 2n+1 (low) and 2n+2 (high).
  function automatic int unsigned node_at(int unsigned lvl, int unsigned way,
                                          int unsigned way_w);
    return ((32'd1 << lvl) - 32'd1) + (way >> (way_w - lvl));
  endfunction
endpackage

// File: rtl/plru_path_upd.sv
module plru_path_upd #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned TB    = NUM_WAYS - 1
) (
  input  logic [TB-1:0]    bits_i,
  input  logic [WAY_W-1:0] way_i,
  output logic [TB-1:0]    bits_o
);
  import plru_pkg::*;

  always_comb begin
    bits_o = bits_i;
    for (int unsigned l = 0; l < WAY_W; l++) begin
      // point away: store the opposite of the way's branch at this level
      bits_o[node_at(l, int'(way_i), WAY_W)] = ~way_i[WAY_W-1-l];
    end
  end
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned TB    = NUM_WAYS - 1
) (
  input  logic [TB-1:0]    bits_i,
  output logic [WAY_W-1:0] way_o
);
  always_comb begin
    int   node;
    logic b;
    node  = 0;
    way_o = '0;
    for (int l = 0; l < int'(WAY_W); l++) begin
      b = bits_i[node];
      way_o[WAY_W-1-l] = b;
      node = 2 * node + 1 + int'(b);
    end
  end
endmodule

// File: rtl/plru_state_ram.sv
module plru_state_ram #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned TB    = NUM_WAYS - 1,
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lkp_set_i,
  output logic [TB-1:0]    lkp_bits_o,
  input  logic [SET_W-1:0] hit_set_i,
  output logic [TB-1:0]    hit_old_o,
  input  logic             hit_we_i,
  input  logic [TB-1:0]    hit_bits_i,
  input  logic [SET_W-1:0] fill_set_i,
  output logic [TB-1:0]    fill_old_o,
  input  logic             fill_we_i,
  input  logic [TB-1:0]    fill_bits_i
);
  logic [TB-1:0] row_q [NUM_SETS];
  logic          clash;

  assign clash      = hit_we_i && fill_we_i && (hit_set_i == fill_set_i);
  assign lkp_bits_o = row_q[lkp_set_i];
  assign hit_old_o  = row_q[hit_set_i];
  assign fill_old_o = row_q[fill_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(NUM_SETS); s++) row_q[s] <= '0;
    end else begin
      if (hit_we_i && !clash) row_q[hit_set_i]  <= hit_bits_i;
      if (fill_we_i)          row_q[fill_set_i] <= fill_bits_i;
    end
  end

  // R6
  fill_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> row_q[$past(fill_set_i)] == $past(fill_bits_i));

  // R7
  dual_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_we_i && fill_we_i && hit_set_i != fill_set_i)
      |=> (row_q[$past(hit_set_i)] == $past(hit_bits_i)) &&
          (row_q[$past(fill_set_i)] == $past(fill_bits_i)));
endmodule

// File: rtl/plru_tree_repl.sv
module plru_tree_repl #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned WAY_W = $clog2(NUM_WAYS),
  localparam int unsigned SET_W = $clog2(NUM_SETS),
  localparam int unsigned TB    = NUM_WAYS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] lkp_set_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             upd_en_i,
  input  logic             hit_vld_i,
  input  logic [SET_W-1:0] hit_set_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic             fill_vld_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i
);
  logic [TB-1:0] lkp_bits, hit_old, hit_new, fill_old, fill_new;
  logic          hit_we, fill_we;

  assign hit_we  = upd_en_i && hit_vld_i;
  assign fill_we = upd_en_i && fill_vld_i;

  plru_state_ram #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lkp_set_i  (lkp_set_i),
    .lkp_bits_o (lkp_bits),
    .hit_set_i  (hit_set_i),
    .hit_old_o  (hit_old),
    .hit_we_i   (hit_we),
    .hit_bits_i (hit_new),
    .fill_set_i (fill_set_i),
    .fill_old_o (fill_old),
    .fill_we_i  (fill_we),
    .fill_bits_i(fill_new)
  );

  plru_path_upd #(.NUM_WAYS(NUM_WAYS)) u_hit_upd (
    .bits_i(hit_old), .way_i(hit_way_i), .bits_o(hit_new)
  );

  plru_path_upd #(.NUM_WAYS(NUM_WAYS)) u_fill_upd (
    .bits_i(fill_old), .way_i(fill_way_i), .bits_o(fill_new)
  );

  plru_victim_sel #(.NUM_WAYS(NUM_WAYS)) u_victim (
    .bits_i(lkp_bits), .way_o(victim_o)
  );

  // R3
  hit_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_we && !(fill_we && fill_set_i == hit_set_i))
      |=> (lkp_set_i != $past(hit_set_i)) || (victim_o != $past(hit_way_i)));

  // R4
  fill_away_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we |=> (lkp_set_i != $past(fill_set_i)) || (victim_o != $past(fill_way_i)));

  // R5
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> (lkp_set_i != $past(lkp_set_i)) || $stable(victim_o));
endmodule

// File: tb/plru_tree_repl_tb_top.sv
module plru_tree_repl_tb_top;
  localparam int CLK_P = 10;
  localparam int NW = 4;
  localparam int NS = 16;

  // {kind(1=hit,2=fill), way, expected victim of set 3 afterwards}
  localparam logic [5:0] VEC [8] = '{
    {2'd1, 2'd0, 2'd2}, {2'd1, 2'd2, 2'd1}, {2'd2, 2'd1, 2'd3}, {2'd2, 2'd3, 2'd0},
    {2'd1, 2'd3, 2'd0}, {2'd1, 2'd0, 2'd2}, {2'd2, 2'd2, 2'd1}, {2'd1, 2'd1, 2'd3}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] lkp_set_i = '0, hit_set_i = '0, fill_set_i = '0;
  logic [1:0] victim_o, hit_way_i = '0, fill_way_i = '0;
  logic       upd_en_i = 1'b1, hit_vld_i = 1'b0, fill_vld_i = 1'b0;
  int         total = 0, bad = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  plru_tree_repl #(.NUM_WAYS(NW), .NUM_SETS(NS)) dut_i (
    .clk_i, .rst_ni, .lkp_set_i, .victim_o, .upd_en_i,
    .hit_vld_i, .hit_set_i, .hit_way_i, .fill_vld_i, .fill_set_i, .fill_way_i
  );

  task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s victim=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic look(int s, logic [1:0] exp, string req);
    lkp_set_i = 4'(s);
    #1;
    chk(req, victim_o, exp);
  endtask

  task automatic step(logic hv, int hs, int hw, logic fv, int fs, int fw, logic en);
    @(negedge clk_i);
    hit_vld_i = hv; hit_set_i = 4'(hs); hit_way_i = 2'(hw);
    fill_vld_i = fv; fill_set_i = 4'(fs); fill_way_i = 2'(fw);
    upd_en_i = en;
    @(posedge clk_i);
    #1;
    hit_vld_i = 1'b0; fill_vld_i = 1'b0; upd_en_i = 1'b1;
  endtask

  initial begin
    #(CLK_P * 20000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2);
    look(9, 2'd0, "R1 during reset");
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    for (int s = 0; s < NS; s++) look(s, 2'd0, "R1 reset state");

    // R2 R3 R4: table walk on set 3
    for (int i = 0; i < 8; i++) begin
      if (VEC[i][5:4] == 2'd1) step(1'b1, 3, int'(VEC[i][3:2]), 1'b0, 0, 0, 1'b1);
      else                     step(1'b0, 0, 0, 1'b1, 3, int'(VEC[i][3:2]), 1'b1);
      look(3, VEC[i][1:0], "R2/R3/R4 table");
    end

    // R5 disabled update ignored, other sets untouched
    step(1'b1, 3, 3, 1'b1, 5, 0, 1'b0);
    look(3, 2'd3, "R5 upd_en low hit");
    look(5, 2'd0, "R5 upd_en low fill");
    look(4, 2'd0, "R5 neighbour set untouched");

    // R6 same-set collision: fill wins
    step(1'b1, 6, 0, 1'b1, 6, 2, 1'b1);
    look(6, 2'd0, "R6 fill wins");

    // R7 different sets both applied
    step(1'b1, 7, 0, 1'b1, 8, 1, 1'b1);
    look(7, 2'd2, "R7 hit side");
    look(8, 2'd2, "R7 fill side");

    // R8 touched way not victim; R2 combinational lookup
    step(1'b1, 8, 2, 1'b0, 0, 0, 1'b1);
    look(8, 2'd0, "R8 after hit way2");
    @(negedge clk_i);
    lkp_set_i = 4'd3; #1; chk("R2 comb lookup A", victim_o, 2'd3);
    lkp_set_i = 4'd7; #1; chk("R2 comb lookup B", victim_o, 2'd2);

    // R1 asynchronous reset mid-run
    #1 rst_ni = 1'b0;
    #1 chk("R1 async clear", victim_o, 2'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    look(3, 2'd0, "R1 after re-reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule